// File: doc/BRIEF.md
# Redundant SAR Weight Calibration Engine

This block sits behind a successive-approximation converter that spends fourteen decision steps on a twelve-bit result. That converter digitises every analog sample twice: once with a known offset added and once with it subtracted. Each of the two raw fourteen-bit codes is turned back into a value by summing a programmable fixed-point weight for every bit that is set. While adaptation is enabled, the mismatch between the two reconstructions drives a least-mean-square correction of all fourteen weights. Once trained, the weights follow the capacitor values that were actually built rather than the values on the drawing.

The weights start at the nominal sub-binary values. They are stored as signed numbers with 8 fractional bits. The correction is the error, scaled by a power-of-two step that shrinks for the less significant positions, and it is applied with the sign of the bit difference between the two codes. The corrected sample is the rounded mean of the two reconstructions, clamped to the twelve-bit range. The current weights are driven out on a flat bus so that the surrounding logic can read them.

Top module: `lmscal_engine`

## Requirements
- R1: After reset, and one edge after `w_init` is sampled high, every weight holds its nominal value times 256. From raw bit 13 down to raw bit 0 the nominal values are 1920, 1024, 544, 288, 144, 80, 40, 24, 12, 8, 6, 2, 2, 1. The weight for raw bit k sits at `weight_bus[k*24 +: 24]` as a two's-complement number.
- R2: The reconstruction of a raw code is the sum of the weights of its set bits, computed with the weights in force at the edge that accepts the sample.
- R3: `out_code` is (Sa + Sb + 256) shifted arithmetically right by 9, where Sa and Sb are the two reconstructions. A result below 0 gives 0 and a result above 4095 gives 4095.
- R4: `out_valid` is high for exactly one cycle, two clock edges after the edge that samples `in_valid` high. Its value follows `in_valid` delayed by two edges.
- R5: The error of a sample is Sa - Sb - offset_lsb * 512, where `offset_lsb` is the signed integer offset that goes with the sample.
- R6: At the edge where the sample's output is registered, each weight k changes when its two raw bits differ. If bit k is 1 in code a and 0 in code b, the weight drops by err >>> s(k). If bit k is 0 in code a and 1 in code b, the weight rises by the same amount. s(k) is 6 for bits 13..10, 7 for bits 9..6, 8 for bits 5..2 and 9 for bits 1..0.
- R7: A sample accepted with `adapt_en` low leaves every weight unchanged, while its output is still produced.
- R8: `w_init` takes priority over an update that falls on the same edge.
- R9: Without an accepted sample, no weight changes, whatever the raw inputs and `adapt_en` are doing.
- R10: Take raw codes from a redundant search that uses mismatched true weights, with the offset applied in both directions. Within 16,384 sample pairs, the summed absolute distance between the weights and the true weights falls below half its starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe for the raw code pair |
| raw_a | input | 14 | Raw code of the conversion with the offset added |
| raw_b | input | 14 | Raw code of the conversion with the offset subtracted |
| offset_lsb | input | 14 | Signed digital offset of the sample, in output LSB |
| adapt_en | input | 1 | Allows the weight update for the sample |
| w_init | input | 1 | Reloads the nominal weights |
| out_valid | output | 1 | Marks a calibrated sample |
| out_code | output | 12 | Calibrated sample |
| weight_bus | output | 336 | All fourteen weights, 24 bits each, fixed point with 8 fractional bits |

## Verification
The assertions assume that `in_valid` is low while reset is held, so that the two-edge valid pipeline starts out empty. They also assume that `w_init` is the only way the weights change apart from an accepted sample with adaptation on. The stimulus keeps `in_valid` and `w_init` low until reset is released and drives all inputs half a cycle away from the sampling edge. It pushes adaptation to both extremes only through bounded training bursts, so the weights stay well inside their 24-bit range. A bench reference computes the outputs and weights on every clock, and this comparison covers back-to-back samples where a weight update lands between two reconstructions.

// File: rtl/lmscal_pkg.sv
// Shared constants and helpers for the weight calibration engine.
// Assumes fourteen raw decision steps with a fixed nominal weight set.
package lmscal_pkg;
    localparam int CAL_NB       = 14;
    localparam int CAL_FRAC     = 8;
    localparam int CAL_WW       = 24;
    localparam int CAL_OFF_W    = 14;
    localparam int CAL_OUT_W    = 12;
    localparam int CAL_MU_BASE  = 6;
    localparam int CAL_MU_GROUP = 4;

    // Nominal weight of raw bit k in output LSB.
    function automatic int nominal_lsb(input int k);
        case (k)
            13: return 1920;
            12: return 1024;
            11: return 544;
            10: return 288;
            9:  return 144;
            8:  return 80;
            7:  return 40;
            6:  return 24;
            5:  return 12;
            4:  return 8;
            3:  return 6;
            2:  return 2;
            1:  return 2;
            default: return 1;
        endcase
    endfunction

    // Right-shift step size of raw bit k; larger shift for lower bits.
    function automatic int mu_shift(input int k, input int nb, input int base, input int grp);
        return base + (nb - 1 - k) / grp;
    endfunction
endpackage

// File: rtl/lmscal_recon.sv
// Weighted-sum reconstruction of one raw code.
// Assumes SW is wide enough to hold the sum of NB signed weights.
module lmscal_recon #(
    parameter int NB = 14,
    parameter int WW = 24,
    parameter int SW = 28
) (
    input  logic [NB-1:0]           bits,
    input  logic [NB*WW-1:0]        w_flat,
    output logic signed [SW-1:0]    sum
);
    // Add the weight of every set bit.
    always_comb begin
        sum = '0;
        for (int k = 0; k < NB; k++) begin
            if (bits[k]) begin
                sum = sum + SW'($signed(w_flat[k*WW +: WW]));
            end
        end
    end
endmodule

// File: rtl/lmscal_outfmt.sv
// Rounded mean of two reconstructions, clamped to the output range.
// Assumes both sums carry FRAC fractional bits.
module lmscal_outfmt #(
    parameter int SW    = 28,
    parameter int FRAC  = 8,
    parameter int OUT_W = 12
) (
    input  logic signed [SW-1:0] sum_a,
    input  logic signed [SW-1:0] sum_b,
    output logic [OUT_W-1:0]     code
);
    localparam int TW = SW + 2;
    localparam logic signed [TW-1:0] HALF = TW'(2 ** FRAC);
    localparam logic signed [TW-1:0] TOPV = TW'(2 ** OUT_W - 1);

    logic signed [TW-1:0] total;
    logic signed [TW-1:0] scaled;

    // Round half up, drop the fraction and the halving bit, then clamp.
    always_comb begin
        total  = TW'(sum_a) + TW'(sum_b) + HALF;
        scaled = total >>> (FRAC + 1);
        if (scaled < 0) begin
            code = '0;
        end else if (scaled > TOPV) begin
            code = '1;
        end else begin
            code = OUT_W'(scaled);
        end
    end
endmodule

// File: rtl/lmscal_wbank.sv
// Weight storage with a per-bit sign-LMS step.
// Assumes err is the registered error of the sample whose bits are given.
module lmscal_wbank
    import lmscal_pkg::*;
#(
    parameter int NB       = CAL_NB,
    parameter int WW       = CAL_WW,
    parameter int FRAC     = CAL_FRAC,
    parameter int EW       = 30,
    parameter int MU_BASE  = CAL_MU_BASE,
    parameter int MU_GROUP = CAL_MU_GROUP
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_nom,
    input  logic                 upd,
    input  logic signed [EW-1:0] err,
    input  logic [NB-1:0]        bits_a,
    input  logic [NB-1:0]        bits_b,
    output logic [NB*WW-1:0]     w_flat
);
    for (genvar k = 0; k < NB; k++) begin : g_w
        localparam int SH = mu_shift(k, NB, MU_BASE, MU_GROUP);
        localparam logic signed [WW-1:0] NOM = WW'(nominal_lsb(k) * (2 ** FRAC));

        logic signed [WW-1:0] w_q;
        logic signed [WW-1:0] step;

        // Scaled error for this bit position.
        always_comb step = WW'(err >>> SH);

        // Hold, reload or step the weight with the sign of the bit difference.
        always_ff @(posedge clk) begin
            if (!rst_n || load_nom) begin
                w_q <= NOM;
            end else if (upd) begin
                if (bits_a[k] && !bits_b[k]) begin
                    w_q <= w_q - step;
                end else if (!bits_a[k] && bits_b[k]) begin
                    w_q <= w_q + step;
                end
            end
        end

        assign w_flat[k*WW +: WW] = w_q;
    end
endmodule

// File: rtl/lmscal_engine.sv
// Calibration engine top: two-stage pipeline of reconstruction, error and
// output formatting, with weights adapted from the error of each sample pair.
// Assumes in_valid is low during reset and that OFF_W + FRAC + 1 < EW.
module lmscal_engine
    import lmscal_pkg::*;
#(
    parameter int NB       = CAL_NB,
    parameter int WW       = CAL_WW,
    parameter int FRAC     = CAL_FRAC,
    parameter int OFF_W    = CAL_OFF_W,
    parameter int OUT_W    = CAL_OUT_W,
    parameter int MU_BASE  = CAL_MU_BASE,
    parameter int MU_GROUP = CAL_MU_GROUP
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [NB-1:0]           raw_a,
    input  logic [NB-1:0]           raw_b,
    input  logic signed [OFF_W-1:0] offset_lsb,
    input  logic                    adapt_en,
    input  logic                    w_init,
    output logic                    out_valid,
    output logic [OUT_W-1:0]        out_code,
    output logic [NB*WW-1:0]        weight_bus
);
    localparam int SW = WW + $clog2(NB);
    localparam int EW = SW + 2;

    logic signed [SW-1:0]    sum_a;
    logic signed [SW-1:0]    sum_b;
    logic                    s1_valid;
    logic                    s1_adapt;
    logic [NB-1:0]           s1_a;
    logic [NB-1:0]           s1_b;
    logic signed [OFF_W-1:0] s1_off;
    logic signed [SW-1:0]    s1_sum_a;
    logic signed [SW-1:0]    s1_sum_b;
    logic signed [EW-1:0]    err;
    logic [OUT_W-1:0]        fmt_code;

    lmscal_recon #(.NB(NB), .WW(WW), .SW(SW)) u_recon_a (
        .bits(raw_a), .w_flat(weight_bus), .sum(sum_a)
    );

    lmscal_recon #(.NB(NB), .WW(WW), .SW(SW)) u_recon_b (
        .bits(raw_b), .w_flat(weight_bus), .sum(sum_b)
    );

    // Stage 1: capture both reconstructions and the sample context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_adapt <= 1'b0;
            s1_a     <= '0;
            s1_b     <= '0;
            s1_off   <= '0;
            s1_sum_a <= '0;
            s1_sum_b <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_adapt <= adapt_en;
            if (in_valid) begin
                s1_a     <= raw_a;
                s1_b     <= raw_b;
                s1_off   <= offset_lsb;
                s1_sum_a <= sum_a;
                s1_sum_b <= sum_b;
            end
        end
    end

    // Error of the pair after removing twice the known offset.
    always_comb err = EW'(s1_sum_a) - EW'(s1_sum_b) - (EW'(s1_off) <<< (FRAC + 1));

    lmscal_outfmt #(.SW(SW), .FRAC(FRAC), .OUT_W(OUT_W)) u_fmt (
        .sum_a(s1_sum_a), .sum_b(s1_sum_b), .code(fmt_code)
    );

    // Stage 2: register the calibrated sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_code <= fmt_code;
            end
        end
    end

    lmscal_wbank #(
        .NB(NB), .WW(WW), .FRAC(FRAC), .EW(EW),
        .MU_BASE(MU_BASE), .MU_GROUP(MU_GROUP)
    ) u_wbank (
        .clk(clk),
        .rst_n(rst_n),
        .load_nom(w_init),
        .upd(s1_valid && s1_adapt),
        .err(err),
        .bits_a(s1_a),
        .bits_b(s1_b),
        .w_flat(weight_bus)
    );
endmodule

// File: rtl/lmscal_engine_chk.sv
// Property checker for the calibration engine, attached by bind.
// Assumes in_valid is low while reset is held.
module lmscal_engine_chk
    import lmscal_pkg::*;
#(
    parameter int NB   = CAL_NB,
    parameter int WW   = CAL_WW,
    parameter int FRAC = CAL_FRAC
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic             w_init,
    input logic             s1_valid,
    input logic             s1_adapt,
    input logic [NB*WW-1:0] weight_bus
);
    function automatic logic [NB*WW-1:0] nom_flat();
        logic [NB*WW-1:0] r;
        r = '0;
        for (int k = 0; k < NB; k++) begin
            r[k*WW +: WW] = WW'(nominal_lsb(k) * (2 ** FRAC));
        end
        return r;
    endfunction

    localparam logic [NB*WW-1:0] NOM = nom_flat();

    a_r1_init_load: assert property (@(posedge clk) disable iff (!rst_n)
        w_init |=> (weight_bus == NOM));

    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(s1_valid));

    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!s1_adapt && !w_init) |=> $stable(weight_bus));

    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!s1_valid && !w_init) |=> $stable(weight_bus));
endmodule

bind lmscal_engine lmscal_engine_chk #(.NB(NB), .WW(WW), .FRAC(FRAC)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .in_valid(in_valid),
    .out_valid(out_valid),
    .w_init(w_init),
    .s1_valid(s1_valid),
    .s1_adapt(s1_adapt),
    .weight_bus(weight_bus)
);

// File: tb/lmscal_engine_test.sv
// Bench: behavioural reference compared on every clock plus directed checks.
module lmscal_engine_test;
    localparam int NB   = 14;
    localparam int WW   = 24;
    localparam int OFFW = 14;
    localparam int OUTW = 12;
    localparam logic [NB-1:0] ONES = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic adapt_en = 1'b0;
    logic w_init = 1'b0;
    logic [NB-1:0] raw_a = '0;
    logic [NB-1:0] raw_b = '0;
    logic signed [OFFW-1:0] offset_lsb = '0;
    logic out_valid;
    logic [OUTW-1:0] out_code;
    logic [NB*WW-1:0] weight_bus;

    always #2.5 clk = ~clk;

    lmscal_engine uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .raw_a(raw_a), .raw_b(raw_b), .offset_lsb(offset_lsb),
        .adapt_en(adapt_en), .w_init(w_init),
        .out_valid(out_valid), .out_code(out_code), .weight_bus(weight_bus)
    );

    int checks = 0;
    int fails = 0;
    bit ckon = 1'b0;
    bit finished = 1'b0;
    int nom[NB] = '{1, 2, 2, 6, 8, 12, 24, 40, 80, 144, 288, 544, 1024, 1920};
    int tru[NB] = '{1, 1, 3, 5, 8, 11, 23, 41, 81, 142, 286, 538, 1028, 1926};

    // reference state
    longint mw[NB];
    bit mv1, men1, mov;
    logic [NB-1:0] ma, mb;
    longint msa, msb, moff, e, sa, sb, r;
    int mout;

    function automatic int shv(int k);
        return 6 + (13 - k) / 4;
    endfunction

    function automatic longint dut_w(int k);
        return longint'($signed(weight_bus[k*WW +: WW]));
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model of one clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NB; k++) mw[k] = longint'(nom[k]) * 256;
            mv1 = 0; men1 = 0; mov = 0; mout = 0;
        end else begin
            mov = mv1;
            if (mv1) begin
                r = (msa + msb + 256) >>> 9;
                mout = (r < 0) ? 0 : ((r > 4095) ? 4095 : int'(r));
            end
            e = msa - msb - moff * 512;
            sa = 0; sb = 0;
            for (int k = 0; k < NB; k++) begin
                if (raw_a[k]) sa += mw[k];
                if (raw_b[k]) sb += mw[k];
            end
            if (w_init) begin
                for (int k = 0; k < NB; k++) mw[k] = longint'(nom[k]) * 256;
            end else if (mv1 && men1) begin
                for (int k = 0; k < NB; k++) begin
                    if (ma[k] && !mb[k]) mw[k] -= (e >>> shv(k));
                    else if (!ma[k] && mb[k]) mw[k] += (e >>> shv(k));
                end
            end
            men1 = adapt_en;
            mv1 = in_valid;
            if (in_valid) begin
                ma = raw_a; mb = raw_b; moff = longint'(offset_lsb); msa = sa; msb = sb;
            end
        end
    end

    // Per-cycle comparison against the reference (R3, R4, R6).
    always @(negedge clk) begin
        if (ckon) begin
            int bad;
            bad = -1;
            chk(out_valid === mov, "R4 out_valid", longint'(out_valid), longint'(mov));
            if (mov) chk(out_code == OUTW'(mout), "R3 out_code", longint'(out_code), longint'(mout));
            for (int k = NB - 1; k >= 0; k--) if (dut_w(k) != mw[k]) bad = k;
            if (bad >= 0) chk(1'b0, $sformatf("R6 weight %0d", bad), dut_w(bad), mw[bad]);
            else chk(1'b1, "R6 weights", 0, 0);
        end
    end

    task automatic send(logic [NB-1:0] a, logic [NB-1:0] b, int off, bit en);
        @(negedge clk);
        raw_a = a; raw_b = b; offset_lsb = OFFW'(off); adapt_en = en; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic init_w();
        @(negedge clk);
        w_init = 1'b1;
        @(negedge clk);
        w_init = 1'b0;
    endtask

    task automatic check_nominal(string tag);
        for (int k = 0; k < NB; k++)
            chk(dut_w(k) == longint'(nom[k]) * 256, tag, dut_w(k), longint'(nom[k]) * 256);
    endtask

    function automatic logic [NB-1:0] sar(longint v);
        logic [NB-1:0] c;
        c = '0;
        for (int k = NB - 1; k >= 0; k--) begin
            if (v >= longint'(tru[k]) * 256) begin
                c[k] = 1'b1;
                v -= longint'(tru[k]) * 256;
            end
        end
        return c;
    endfunction

    function automatic longint dist_true();
        longint d;
        d = 0;
        for (int k = 0; k < NB; k++) begin
            longint t;
            t = dut_w(k) - longint'(tru[k]) * 256;
            d += (t < 0) ? -t : t;
        end
        return d;
    endfunction

    initial begin
        longint d0, d1, ev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ckon = 1'b1;
        // R1: reset state
        check_nominal("R1 reset weight");
        chk(out_valid == 1'b0, "R4 reset out_valid", longint'(out_valid), 0);

        // R2/R4: LSB only in both codes -> 1
        send(14'h0001, 14'h0001, 0, 1'b0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R4 latency", longint'(out_valid), 1);
        chk(out_code == 12'd1, "R2 lsb sum", longint'(out_code), 1);
        @(negedge clk);
        chk(out_valid == 1'b0, "R4 single pulse", longint'(out_valid), 0);

        // R3: half-LSB mean rounds up
        send(14'h0001, 14'h0000, 0, 1'b0);
        @(negedge clk);
        chk(out_code == 12'd1, "R3 round half up", longint'(out_code), 1);

        // R2: full scale and MSB-only
        send(ONES, ONES, 0, 1'b0);
        @(negedge clk);
        chk(out_code == 12'd4095, "R2 all ones", longint'(out_code), 4095);
        send(14'h2000, 14'h0000, 0, 1'b0);
        @(negedge clk);
        chk(out_code == 12'd960, "R2 msb half", longint'(out_code), 960);

        // R5/R6: one adaptation step, bit 13 in a, bit 12 in b, offset 5
        send(14'h2000, 14'h1000, 5, 1'b1);
        @(negedge clk);
        ev = (longint'(1920 - 1024) * 256 - 2 * 5 * 256) >>> 6;
        chk(dut_w(13) == 1920 * 256 - ev, "R5 R6 msb step down", dut_w(13), 1920 * 256 - ev);
        chk(dut_w(12) == 1024 * 256 + ev, "R5 R6 bit12 step up", dut_w(12), 1024 * 256 + ev);
        chk(dut_w(11) == 544 * 256, "R6 equal bits untouched", dut_w(11), 544 * 256);

        // R8: reload on the same edge as an update
        @(negedge clk);
        raw_a = ONES; raw_b = '0; offset_lsb = '0; adapt_en = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; w_init = 1'b1;
        @(negedge clk);
        w_init = 1'b0;
        check_nominal("R8 reload wins");

        // R7: many accepted samples with adaptation off
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            raw_a = NB'($urandom); raw_b = NB'($urandom);
            offset_lsb = OFFW'($urandom); adapt_en = 1'b0; in_valid = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check_nominal("R7 frozen weight");

        // R9: no accepted sample, adaptation on, inputs toggling
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            raw_a = NB'($urandom); raw_b = NB'($urandom); adapt_en = 1'b1;
        end
        repeat (2) @(negedge clk);
        check_nominal("R9 idle weight");

        // R2/R6: back-to-back adapting samples (checked against the reference)
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            raw_a = NB'($urandom); raw_b = NB'($urandom);
            offset_lsb = OFFW'($urandom_range(200, 0)); adapt_en = 1'b1; in_valid = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        init_w();

        // R3: drive weights up, then expect the upper clamp
        for (int i = 0; i < 60; i++) send(ONES, '0, 8191, 1'b1);
        send(ONES, ONES, 0, 1'b0);
        @(negedge clk);
        chk(out_code == 12'd4095, "R3 clamp high", longint'(out_code), 4095);
        init_w();

        // R3: drive weights down, then expect the lower clamp
        for (int i = 0; i < 60; i++) send('0, ONES, 8191, 1'b1);
        send(ONES, ONES, 0, 1'b0);
        @(negedge clk);
        chk(out_code == 12'd0, "R3 clamp low", longint'(out_code), 0);
        init_w();

        // R10: convergence towards mismatched true weights
        d0 = dist_true();
        for (int i = 0; i < 16384; i++) begin
            longint x0;
            x0 = longint'($urandom_range((4094 - 100) * 256 - 1, 100 * 256));
            send(sar(x0 + 100 * 256), sar(x0 - 100 * 256), 100, 1'b1);
        end
        repeat (2) @(negedge clk);
        d1 = dist_true();
        chk(d1 * 2 < d0, "R10 convergence", d1, d0 / 2);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule